// File: doc/BRIEF.md
# Triggered ADC Conversion-Slot Scheduler

This block is the digital control core of an analog-to-digital converter. The converter is not driven by a fixed ordered sequencer. It works from sixteen independent conversion slots, and each slot describes one conversion of one channel. A slot carries three settings: the event that starts it, the input to convert, and the length of its acquisition window. Several slots may share a trigger, a channel or a window. A single event can therefore oversample one input or sweep several inputs. Software can also force any slot directly.

Trigger edges and force requests set a pending flag in every slot they address. The scheduler serves one pending slot at a time. It searches in round-robin order, starting just after the slot it converted last. For the chosen slot it holds a sample phase, strobes the converter, and waits for the converter's done pulse. It then stores the result in that slot's result register and issues an end-of-conversion pulse. Eight interrupt lines can each follow the end-of-conversion of one chosen slot. A slot can take its trigger from one of those lines instead of from an external source, which allows continuous, self-restarting conversion.

The converter side is a plain strobe interface, not a stream. The converter cannot be stalled, so there is no back-pressure in either direction. A done pulse is accepted only while a conversion is outstanding and is ignored at any other time. Results are read combinationally through a slot-indexed read port.

Top module: `adc_slot_sched`

## Requirements
- R1: A configuration write (`cfg_we`) stores, for slot `cfg_slot`, a trigger code, a 4-bit channel, a 6-bit window and an interrupt-trigger selection. The channel of the slot in service appears on `conv_chan_o` from the first sample cycle through the start strobe. Channel bit 3 selects sample-and-hold side B (1) or side A (0), and bits 2:0 select one of eight inputs on that side.
- R2: A rising edge on `trig_i[t]` sets the pending flag of every slot whose trigger code is t+1. Each such slot is then converted once.
- R3: A high `force_i[s]` in a cycle sets the pending flag of slot s, whatever its trigger code.
- R4: A pending flag clears in the cycle its slot is granted. A request that arrives while the flag is set, and is not being cleared in that same cycle, is lost and sets `ovf_o[s]`. `ovf_o[s]` stays set until a cycle with `ovf_clr_i[s]` high. A request that arrives in the grant cycle sets the flag again and is not lost.
- R5: Among pending slots, the grant goes to the first slot in increasing index order, wrapping, after the last slot to complete. After reset the last slot counts as 15.
- R6: A granted slot with window w drives `sample_o` high for exactly w+1 cycles. `conv_start_o` is then high for exactly one cycle.
- R7: Only one conversion is in flight at a time. A `conv_done_i` pulse outside the wait for a result has no effect.
- R8: When `conv_done_i` arrives during the wait, `conv_data_i` is written to the serviced slot's result register. In the same cycle `eoc_o` shows a one-hot pulse for that slot. `rd_data_o` shows the result register named by `rd_slot_i`.
- R9: When interrupt line k is enabled, its flag `int_o[k]` sets on the end-of-conversion of its selected slot. The flag stays set until a cycle with `int_clr_i[k]` high. If a set and a clear fall in the same cycle, the set wins.
- R10: A slot with its interrupt-trigger enable set is triggered by the set event of its chosen interrupt line and ignores `trig_i`.
- R11: Trigger code 0 means no hardware trigger. Such a slot starts only by force.
- R12: After reset all outputs are low, no slot is pending and every result register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Slot configuration write strobe |
| cfg_slot | input | 4 | Slot being configured |
| cfg_tsel | input | 5 | Trigger code: 0 none, t+1 selects trig_i[t] |
| cfg_chan | input | 4 | Channel: bit 3 side, bits 2:0 input |
| cfg_win | input | 6 | Acquisition window (cycles minus one) |
| cfg_isrc_en | input | 1 | Take trigger from an interrupt line |
| cfg_isrc_line | input | 3 | Interrupt line used as trigger |
| icfg_we | input | 1 | Interrupt line configuration write strobe |
| icfg_line | input | 3 | Interrupt line being configured |
| icfg_slot | input | 4 | Slot whose end-of-conversion drives the line |
| icfg_en | input | 1 | Line enable |
| trig_i | input | 16 | External trigger sources, edge-detected |
| force_i | input | 16 | Per-slot software force |
| int_clr_i | input | 8 | Write-one-to-clear for interrupt flags |
| ovf_clr_i | input | 16 | Write-one-to-clear for overflow flags |
| sample_o | output | 1 | Acquisition phase active |
| conv_start_o | output | 1 | Converter start strobe |
| conv_chan_o | output | 4 | Channel of the slot in service |
| conv_done_i | input | 1 | Converter result valid strobe |
| conv_data_i | input | 12 | Converter result |
| eoc_o | output | 16 | Per-slot end-of-conversion pulse |
| int_o | output | 8 | Interrupt flags |
| ovf_o | output | 16 | Sticky lost-trigger flags |
| rd_slot_i | input | 4 | Result register select |
| rd_data_o | output | 12 | Selected result register |

## Verification
Two pairs of events can fall in the same cycle. A slot can be requested in the very cycle its pending flag clears at grant. An end-of-conversion can set an interrupt flag in the cycle software clears it. The bench provokes the first by holding a force for two cycles while the scheduler is idle. It provokes the second by holding the clear high across a whole conversion of the selected slot. A cycle-accurate behavioural model judges every cycle. Directed checks then confirm that the slot converts twice without overflow and that the flag was seen set while the clear was high.

// File: rtl/adc_sched_pkg.sv
package adc_sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_LAUNCH = 2'd2,
    ST_WAIT   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adc_slot_cfg.sv
module adc_slot_cfg #(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_TRIG  = 16,
  parameter int NUM_INT   = 8,
  parameter int CH_W      = 4,
  parameter int WIN_W     = 6,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int TSEL_W   = $clog2(NUM_TRIG + 1),
  localparam int INT_W    = $clog2(NUM_INT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [SLOT_W-1:0]    cfg_slot,
  input  logic [TSEL_W-1:0]    cfg_tsel,
  input  logic [CH_W-1:0]      cfg_chan,
  input  logic [WIN_W-1:0]     cfg_win,
  input  logic                 cfg_isrc_en,
  input  logic [INT_W-1:0]     cfg_isrc_line,
  input  logic [NUM_TRIG-1:0]  trig_rise,
  input  logic [NUM_INT-1:0]   int_evt,
  input  logic [NUM_SLOTS-1:0] force_req,
  input  logic [SLOT_W-1:0]    pick,
  output logic [NUM_SLOTS-1:0] hit,
  output logic [CH_W-1:0]      sel_chan,
  output logic [WIN_W-1:0]     sel_win
);
  logic [TSEL_W-1:0] tsel_q [NUM_SLOTS];
  logic [CH_W-1:0]   chan_q [NUM_SLOTS];
  logic [WIN_W-1:0]  win_q  [NUM_SLOTS];
  logic              isen_q [NUM_SLOTS];
  logic [INT_W-1:0]  isl_q  [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic ext_hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tsel_q[s] <= '0;
        chan_q[s] <= '0;
        win_q[s]  <= '0;
        isen_q[s] <= 1'b0;
        isl_q[s]  <= '0;
      end else if (cfg_we && cfg_slot == SLOT_W'(s)) begin
        tsel_q[s] <= cfg_tsel;
        chan_q[s] <= cfg_chan;
        win_q[s]  <= cfg_win;
        isen_q[s] <= cfg_isrc_en;
        isl_q[s]  <= cfg_isrc_line;
      end
    end

    // code 0 matches no source; code t+1 matches source t
    always_comb begin
      ext_hit = 1'b0;
      for (int t = 0; t < NUM_TRIG; t++) begin
        if (tsel_q[s] == TSEL_W'(t + 1)) ext_hit = trig_rise[t];
      end
    end

    assign hit[s] = force_req[s] |
                    (isen_q[s] ? int_evt[isl_q[s]] : ext_hit);
  end

  assign sel_chan = chan_q[pick];
  assign sel_win  = win_q[pick];
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_sched_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int CH_W      = 4,
  parameter int WIN_W     = 6,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] pend,
  input  logic [CH_W-1:0]      sel_chan,
  input  logic [WIN_W-1:0]     sel_win,
  input  logic                 conv_done_i,
  output logic [SLOT_W-1:0]    pick,
  output logic [NUM_SLOTS-1:0] grant_vec,
  output logic                 sample_o,
  output logic                 conv_start_o,
  output logic [CH_W-1:0]      conv_chan_o,
  output logic                 eoc_valid,
  output logic [SLOT_W-1:0]    cur_slot
);
  seq_state_e        st_q;
  logic [WIN_W-1:0]  cnt_q;
  logic [SLOT_W-1:0] cur_q, last_q, cand;
  logic [CH_W-1:0]   chan_q;
  logic              found, grant;

  // round-robin search beginning one past the last completed slot
  // (slot count is a power of two, so the index wraps by overflow)
  always_comb begin
    found = 1'b0;
    pick  = last_q;
    cand  = last_q;
    for (int i = 1; i <= NUM_SLOTS; i++) begin
      cand = last_q + SLOT_W'(i);
      if (!found && pend[cand]) begin
        found = 1'b1;
        pick  = cand;
      end
    end
  end

  assign grant = (st_q == ST_IDLE) && found;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_grant
    assign grant_vec[s] = grant && (pick == SLOT_W'(s));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      cur_q  <= '0;
      last_q <= SLOT_W'(NUM_SLOTS - 1);
      chan_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (grant) begin
          st_q   <= ST_SAMPLE;
          cur_q  <= pick;
          cnt_q  <= sel_win;
          chan_q <= sel_chan;
        end
        ST_SAMPLE: begin
          if (cnt_q == '0) st_q <= ST_LAUNCH;
          else             cnt_q <= cnt_q - 1'b1;
        end
        ST_LAUNCH: st_q <= ST_WAIT;
        ST_WAIT: if (conv_done_i) begin
          st_q   <= ST_IDLE;
          last_q <= cur_q;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sample_o     = (st_q == ST_SAMPLE);
  assign conv_start_o = (st_q == ST_LAUNCH);
  assign conv_chan_o  = chan_q;
  assign eoc_valid    = (st_q == ST_WAIT) && conv_done_i;
  assign cur_slot     = cur_q;
endmodule

// File: rtl/adc_int_route.sv
module adc_int_route #(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_INT   = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int INT_W    = $clog2(NUM_INT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 icfg_we,
  input  logic [INT_W-1:0]     icfg_line,
  input  logic [SLOT_W-1:0]    icfg_slot,
  input  logic                 icfg_en,
  input  logic [NUM_SLOTS-1:0] eoc,
  input  logic [NUM_INT-1:0]   int_clr,
  output logic [NUM_INT-1:0]   int_evt,
  output logic [NUM_INT-1:0]   int_flag
);
  for (genvar k = 0; k < NUM_INT; k++) begin : g_line
    logic [SLOT_W-1:0] sel_q;
    logic              en_q, flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q <= '0;
        en_q  <= 1'b0;
      end else if (icfg_we && icfg_line == INT_W'(k)) begin
        sel_q <= icfg_slot;
        en_q  <= icfg_en;
      end
    end

    assign int_evt[k] = en_q && eoc[sel_q];

    // a set in the same cycle as a clear wins
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q <= 1'b0;
      else if (int_evt[k]) flag_q <= 1'b1;
      else if (int_clr[k]) flag_q <= 1'b0;
    end

    assign int_flag[k] = flag_q;
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NUM_SLOTS = 16,
  parameter int RES_W     = 12,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [RES_W-1:0]  wr_data,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [RES_W-1:0]  rd_data
);
  logic [RES_W-1:0] res_q [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_res
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 res_q[s] <= '0;
      else if (wr_en && wr_slot == SLOT_W'(s))    res_q[s] <= wr_data;
    end
  end

  assign rd_data = res_q[rd_slot];
endmodule

// File: rtl/adc_slot_sched.sv
module adc_slot_sched #(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_TRIG  = 16,
  parameter int NUM_INT   = 8,
  parameter int CH_W      = 4,
  parameter int WIN_W     = 6,
  parameter int RES_W     = 12,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int TSEL_W   = $clog2(NUM_TRIG + 1),
  localparam int INT_W    = $clog2(NUM_INT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [SLOT_W-1:0]    cfg_slot,
  input  logic [TSEL_W-1:0]    cfg_tsel,
  input  logic [CH_W-1:0]      cfg_chan,
  input  logic [WIN_W-1:0]     cfg_win,
  input  logic                 cfg_isrc_en,
  input  logic [INT_W-1:0]     cfg_isrc_line,
  input  logic                 icfg_we,
  input  logic [INT_W-1:0]     icfg_line,
  input  logic [SLOT_W-1:0]    icfg_slot,
  input  logic                 icfg_en,
  input  logic [NUM_TRIG-1:0]  trig_i,
  input  logic [NUM_SLOTS-1:0] force_i,
  input  logic [NUM_INT-1:0]   int_clr_i,
  input  logic [NUM_SLOTS-1:0] ovf_clr_i,
  output logic                 sample_o,
  output logic                 conv_start_o,
  output logic [CH_W-1:0]      conv_chan_o,
  input  logic                 conv_done_i,
  input  logic [RES_W-1:0]     conv_data_i,
  output logic [NUM_SLOTS-1:0] eoc_o,
  output logic [NUM_INT-1:0]   int_o,
  output logic [NUM_SLOTS-1:0] ovf_o,
  input  logic [SLOT_W-1:0]    rd_slot_i,
  output logic [RES_W-1:0]     rd_data_o
);
  logic [NUM_TRIG-1:0]  trig_q, trig_rise;
  logic [NUM_SLOTS-1:0] pend_q, ovf_q, hit, grant_vec;
  logic [NUM_INT-1:0]   int_evt;
  logic [SLOT_W-1:0]    pick, cur_slot;
  logic [CH_W-1:0]      sel_chan;
  logic [WIN_W-1:0]     sel_win;
  logic                 eoc_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= '0;
    else        trig_q <= trig_i;
  end
  assign trig_rise = trig_i & ~trig_q;

  // pending flags and lost-request tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      ovf_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~grant_vec) | hit;
      ovf_q  <= (ovf_q & ~ovf_clr_i) | (hit & pend_q & ~grant_vec);
    end
  end
  assign ovf_o = ovf_q;

  adc_slot_cfg #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_TRIG(NUM_TRIG), .NUM_INT(NUM_INT),
    .CH_W(CH_W), .WIN_W(WIN_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_tsel(cfg_tsel),
    .cfg_chan(cfg_chan), .cfg_win(cfg_win),
    .cfg_isrc_en(cfg_isrc_en), .cfg_isrc_line(cfg_isrc_line),
    .trig_rise(trig_rise), .int_evt(int_evt), .force_req(force_i),
    .pick(pick), .hit(hit), .sel_chan(sel_chan), .sel_win(sel_win)
  );

  adc_conv_seq #(
    .NUM_SLOTS(NUM_SLOTS), .CH_W(CH_W), .WIN_W(WIN_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .pend(pend_q),
    .sel_chan(sel_chan), .sel_win(sel_win), .conv_done_i(conv_done_i),
    .pick(pick), .grant_vec(grant_vec), .sample_o(sample_o),
    .conv_start_o(conv_start_o), .conv_chan_o(conv_chan_o),
    .eoc_valid(eoc_valid), .cur_slot(cur_slot)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_eoc
    assign eoc_o[s] = eoc_valid && (cur_slot == SLOT_W'(s));
  end

  adc_int_route #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_INT(NUM_INT)
  ) u_int (
    .clk(clk), .rst_n(rst_n),
    .icfg_we(icfg_we), .icfg_line(icfg_line), .icfg_slot(icfg_slot),
    .icfg_en(icfg_en), .eoc(eoc_o), .int_clr(int_clr_i),
    .int_evt(int_evt), .int_flag(int_o)
  );

  adc_result_bank #(
    .NUM_SLOTS(NUM_SLOTS), .RES_W(RES_W)
  ) u_res (
    .clk(clk), .rst_n(rst_n),
    .wr_en(eoc_valid), .wr_slot(cur_slot), .wr_data(conv_data_i),
    .rd_slot(rd_slot_i), .rd_data(rd_data_o)
  );
endmodule

// File: rtl/adc_slot_sched_chk.sv
module adc_slot_sched_chk #(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_INT   = 8,
  parameter int CH_W      = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sample_o,
  input logic                 conv_start_o,
  input logic [CH_W-1:0]      conv_chan_o,
  input logic                 conv_done_i,
  input logic [NUM_SLOTS-1:0] eoc_o,
  input logic [NUM_INT-1:0]   int_o,
  input logic [NUM_INT-1:0]   int_clr_i,
  input logic [NUM_SLOTS-1:0] ovf_o,
  input logic [NUM_SLOTS-1:0] ovf_clr_i
);
  // R6
  start_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> $past(sample_o));

  // R6
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> (!conv_start_o && !sample_o));

  // R1
  chan_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> $stable(conv_chan_o));

  // R7
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sample_o, conv_start_o, |eoc_o}));

  // R8
  eoc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eoc_o));

  // R8
  eoc_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|eoc_o) |-> conv_done_i);

  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(ovf_o) & ~$past(ovf_clr_i) & ~ovf_o) == '0));

  for (genvar k = 0; k < NUM_INT; k++) begin : g_line
    // R9
    int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(int_o[k]) && !$past(int_clr_i[k])) |-> int_o[k]);
  end
endmodule

bind adc_slot_sched adc_slot_sched_chk #(
  .NUM_SLOTS(NUM_SLOTS), .NUM_INT(NUM_INT), .CH_W(CH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_o(sample_o), .conv_start_o(conv_start_o),
  .conv_chan_o(conv_chan_o), .conv_done_i(conv_done_i), .eoc_o(eoc_o),
  .int_o(int_o), .int_clr_i(int_clr_i), .ovf_o(ovf_o), .ovf_clr_i(ovf_clr_i)
);

// File: tb/adc_slot_sched_bench.sv
module adc_slot_sched_bench;
  localparam int NS = 16, NT = 16, NI = 8, CHW = 4, WW = 6, RW = 12;
  localparam int SW = 4, TW = 5, IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_isrc_en = 0, icfg_we = 0, icfg_en = 0;
  logic [SW-1:0] cfg_slot = '0, icfg_slot = '0, rd_slot_i = '0;
  logic [TW-1:0] cfg_tsel = '0;
  logic [CHW-1:0] cfg_chan = '0, conv_chan_o;
  logic [WW-1:0] cfg_win = '0;
  logic [IW-1:0] cfg_isrc_line = '0, icfg_line = '0;
  logic [NT-1:0] trig_i = '0;
  logic [NS-1:0] force_i = '0, ovf_clr_i = '0, eoc_o, ovf_o;
  logic [NI-1:0] int_clr_i = '0, int_o;
  logic sample_o, conv_start_o, conv_done_i = 1'b0;
  logic [RW-1:0] conv_data_i = '0, rd_data_o;

  always #4 clk = ~clk;

  adc_slot_sched u_adc_slot_sched (.*);

  int checks = 0, errors = 0;
  int eoc_log[$];
  int scount = 0, last_len = 0, last_chan = 0, cd = 0, seq = 0;
  bit spur = 0, flag_seen = 0, run_cmp = 0;

  // behavioural reference state
  logic [NS-1:0] m_pend, m_ovf;
  logic [NI-1:0] m_flag;
  logic [NT-1:0] m_tq;
  logic [RW-1:0] m_res [NS];
  int m_st, m_cnt, m_cur, m_last, m_chanq;
  int m_tsel[NS], m_chan[NS], m_win[NS], m_isen[NS], m_isl[NS];
  int m_isel[NI], m_ien[NI];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [NS-1:0] exp_eoc();
    return (m_st == 3 && conv_done_i) ? (NS'(1) << m_cur) : '0;
  endfunction

  task automatic model_reset();
    m_pend = '0; m_ovf = '0; m_flag = '0; m_tq = '0;
    m_st = 0; m_cnt = 0; m_cur = 0; m_last = NS - 1; m_chanq = 0;
    for (int s = 0; s < NS; s++) begin
      m_tsel[s] = 0; m_chan[s] = 0; m_win[s] = 0; m_isen[s] = 0; m_isl[s] = 0;
      m_res[s] = '0;
    end
    for (int k = 0; k < NI; k++) begin m_isel[k] = 0; m_ien[k] = 0; end
  endtask

  task automatic model_step();
    logic [NS-1:0] eoc, hit, clr;
    logic [NI-1:0] ev;
    int pick;
    bit go;
    eoc = exp_eoc();
    for (int k = 0; k < NI; k++) ev[k] = (m_ien[k] != 0) && eoc[m_isel[k]];
    for (int s = 0; s < NS; s++) begin
      if (m_isen[s] != 0) hit[s] = force_i[s] | ev[m_isl[s]];
      else hit[s] = force_i[s] | (m_tsel[s] != 0 && trig_i[m_tsel[s]-1] && !m_tq[m_tsel[s]-1]);
    end
    go = 0; pick = 0; clr = '0;
    if (m_st == 0) begin
      for (int i = 1; i <= NS; i++) begin
        int idx = (m_last + i) % NS;
        if (!go && m_pend[idx]) begin go = 1; pick = idx; end
      end
    end
    if (go) clr[pick] = 1'b1;
    m_ovf  = (m_ovf & ~ovf_clr_i) | (hit & m_pend & ~clr);
    m_pend = (m_pend & ~clr) | hit;
    m_flag = (m_flag & ~int_clr_i) | ev;
    if (|eoc) m_res[m_cur] = conv_data_i;
    case (m_st)
      0: if (go) begin m_st = 1; m_cur = pick; m_cnt = m_win[pick]; m_chanq = m_chan[pick]; end
      1: if (m_cnt == 0) m_st = 2; else m_cnt--;
      2: m_st = 3;
      default: if (conv_done_i) begin m_st = 0; m_last = m_cur; end
    endcase
    m_tq = trig_i;
    if (cfg_we) begin
      m_tsel[cfg_slot] = cfg_tsel; m_chan[cfg_slot] = cfg_chan; m_win[cfg_slot] = cfg_win;
      m_isen[cfg_slot] = cfg_isrc_en; m_isl[cfg_slot] = cfg_isrc_line;
    end
    if (icfg_we) begin m_isel[icfg_line] = icfg_slot; m_ien[icfg_line] = icfg_en; end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  // converter stand-in: result three cycles after the start strobe
  always @(negedge clk) begin
    conv_done_i = 1'b0;
    if (cd > 0) begin
      cd--;
      if (cd == 0) begin conv_done_i = 1'b1; conv_data_i = {conv_chan_o, seq[7:0]}; seq++; end
    end else if (spur) begin
      conv_done_i = 1'b1; conv_data_i = 12'hABC;
    end
    if (conv_start_o) cd = 3;
  end

  // per-cycle comparison against the model
  always begin
    @(negedge clk); #3;
    if (rst_n && run_cmp) begin
      check(sample_o == (m_st == 1), "R6", "sample_o", sample_o, m_st == 1);
      check(conv_start_o == (m_st == 2), "R6", "conv_start_o", conv_start_o, m_st == 2);
      if (sample_o || conv_start_o)
        check(conv_chan_o == CHW'(m_chanq), "R1", "conv_chan_o", conv_chan_o, m_chanq);
      check(eoc_o == exp_eoc(), "R8", "eoc_o", eoc_o, exp_eoc());
      check(int_o == m_flag, "R9", "int_o", int_o, m_flag);
      check(ovf_o == m_ovf, "R4", "ovf_o", ovf_o, m_ovf);
      check(rd_data_o == m_res[rd_slot_i], "R8", "rd_data_o", rd_data_o, m_res[rd_slot_i]);
      for (int s = 0; s < NS; s++) if (eoc_o[s]) eoc_log.push_back(s);
      if (int_o[2] && int_clr_i[2]) flag_seen = 1;
      if (sample_o) scount++;
      if (conv_start_o) begin last_len = scount; last_chan = conv_chan_o; scount = 0; end
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr_slot(int s, int tsel, int chan, int win, int isen, int isl);
    step();
    cfg_slot = SW'(s); cfg_tsel = TW'(tsel); cfg_chan = CHW'(chan); cfg_win = WW'(win);
    cfg_isrc_en = isen[0]; cfg_isrc_line = IW'(isl); cfg_we = 1;
    step(); cfg_we = 0;
  endtask

  task automatic wr_int(int line, int slot, int en);
    step();
    icfg_line = IW'(line); icfg_slot = SW'(slot); icfg_en = en[0]; icfg_we = 1;
    step(); icfg_we = 0;
  endtask

  task automatic wait_idle();
    int g = 0;
    do begin step(); g++; end
    while (!(m_st == 0 && m_pend == '0 && cd == 0 && !conv_done_i) && g < 3000);
    step(); step();
  endtask

  task automatic pulse_trig(int t);
    step(); trig_i[t] = 1; step(); step(); trig_i = '0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int n;
    repeat (4) step();
    rst_n = 1; run_cmp = 1;
    // R12 reset state
    rd_slot_i = 4'd9; step();
    check(!sample_o && !conv_start_o && eoc_o == '0, "R12", "phase outputs", {sample_o, conv_start_o}, 0);
    check(int_o == '0 && ovf_o == '0, "R12", "flags", {int_o, ovf_o}, 0);
    check(rd_data_o == '0, "R12", "result reg", rd_data_o, 0);

    // R2: one edge starts three slots sharing a trigger
    wr_slot(3, 2, 'hA, 5, 0, 0);
    wr_slot(4, 2, 'h1, 0, 0, 0);
    wr_slot(7, 2, 'h9, 2, 0, 0);
    eoc_log.delete(); pulse_trig(1); wait_idle();
    check(eoc_log.size() == 3, "R2", "conversions", eoc_log.size(), 3);
    if (eoc_log.size() == 3)
      check(eoc_log[0] == 3 && eoc_log[1] == 4 && eoc_log[2] == 7, "R2", "order", eoc_log[2], 7);
    check(last_chan == 9, "R1", "last channel", last_chan, 9);
    check(last_len == 3, "R6", "sample length win 2", last_len, 3);

    // R11: code 0 slots ignore every trigger
    eoc_log.delete(); step(); trig_i = '1; step(); step(); trig_i = '0; wait_idle();
    check(eoc_log.size() == 3, "R11", "only coded slots run", eoc_log.size(), 3);

    // R5 / R3: forced slots served round-robin after slot 7
    eoc_log.delete(); step(); force_i = 16'h1204; step(); force_i = '0; wait_idle();
    check(eoc_log.size() == 3, "R3", "forced conversions", eoc_log.size(), 3);
    if (eoc_log.size() == 3)
      check(eoc_log[0] == 9 && eoc_log[1] == 12 && eoc_log[2] == 2, "R5", "rr order", eoc_log[0], 9);

    // R6: long window
    wr_slot(5, 0, 3, 10, 0, 0);
    step(); force_i[5] = 1; step(); force_i = '0; wait_idle();
    check(last_len == 11, "R6", "sample length win 10", last_len, 11);
    check(last_chan == 3, "R1", "channel slot 5", last_chan, 3);

    // R4: lost request while pending
    step(); force_i[5] = 1; step(); force_i = '0;
    repeat (3) step();
    force_i[6] = 1; step(); force_i = '0; step();
    force_i[6] = 1; step(); force_i = '0;
    check(ovf_o[6] == 1'b1, "R4", "ovf slot 6", ovf_o[6], 1);
    check(ovf_o[5] == 1'b0, "R4", "ovf slot 5", ovf_o[5], 0);
    wait_idle();
    check(ovf_o[6] == 1'b1, "R4", "ovf sticky", ovf_o[6], 1);
    ovf_clr_i[6] = 1; step(); ovf_clr_i = '0;
    check(ovf_o[6] == 1'b0, "R4", "ovf cleared", ovf_o[6], 0);

    // R4: request in the grant cycle is kept
    eoc_log.delete(); step(); force_i[13] = 1; step(); step(); force_i = '0; wait_idle();
    n = 0; foreach (eoc_log[i]) if (eoc_log[i] == 13) n++;
    check(n == 2, "R4", "slot 13 runs twice", n, 2);
    check(ovf_o[13] == 1'b0, "R4", "no ovf at grant", ovf_o[13], 0);

    // R9: interrupt set, hold, clear, set-wins
    wr_int(2, 3, 1);
    pulse_trig(1); wait_idle();
    check(int_o[2] == 1'b1, "R9", "int set", int_o[2], 1);
    repeat (10) step();
    check(int_o[2] == 1'b1, "R9", "int held", int_o[2], 1);
    int_clr_i[2] = 1; step(); int_clr_i = '0;
    check(int_o[2] == 1'b0, "R9", "int cleared", int_o[2], 0);
    flag_seen = 0; step(); int_clr_i[2] = 1;
    pulse_trig(1); wait_idle(); int_clr_i = '0; step();
    check(flag_seen == 1, "R9", "set beats clear", flag_seen, 1);
    check(int_o[2] == 1'b0, "R9", "int after clear", int_o[2], 0);

    // R10: chained slot triggered from interrupt line 2
    wr_slot(8, 0, 6, 1, 1, 2);
    eoc_log.delete(); pulse_trig(1); wait_idle();
    check(eoc_log.size() == 4, "R10", "chained count", eoc_log.size(), 4);
    if (eoc_log.size() == 4)
      check(eoc_log[3] == 8, "R10", "chained slot", eoc_log[3], 8);
    int_clr_i = '1; step(); int_clr_i = '0;

    // R10: self-restarting slot, then stop it
    wr_int(0, 11, 1); wr_slot(11, 0, 5, 0, 1, 0);
    eoc_log.delete(); step(); force_i[11] = 1; step(); force_i = '0;
    repeat (60) step();
    n = 0; foreach (eoc_log[i]) if (eoc_log[i] == 11) n++;
    check(n >= 3, "R10", "continuous runs", n, 3);
    wr_int(0, 11, 0); wait_idle();
    check(sample_o == 1'b0, "R10", "loop stopped", sample_o, 0);

    // R7: stray done while idle
    eoc_log.delete(); spur = 1; step(); spur = 0; repeat (5) step();
    check(eoc_log.size() == 0, "R7", "stray done ignored", eoc_log.size(), 0);

    // R8: result readback
    for (int s = 0; s < NS; s++) begin
      rd_slot_i = SW'(s); step();
      check(rd_data_o == m_res[s], "R8", "result readback", rd_data_o, m_res[s]);
    end
    finish_run();
  end
endmodule